// File: doc/BRIEF.md
# Extended Golay Decoder

This block decodes a 24-bit received word protected by the extended binary Golay code, which has 12 data bits and a minimum distance of 8. It returns the 12 recovered data bits with two flags. One flag says that a nonzero error pattern was corrected. The other says that the word holds more errors than the code can repair. The block corrects any pattern of up to three flipped bits. It never miscorrects a pattern of exactly four flipped bits: it reports that pattern as uncorrectable.

The codeword is systematic. Bits [23:12] carry the data word d. Bits [11:0] carry the parity p = d·B over GF(2), where B is a fixed symmetric 12x12 matrix and B·B = I. The decoder works in three steps:

- It forms the syndrome s = p ⊕ d·B.
- It searches for a low-weight error pattern, first with s and then with s·B.
- It flips the data bits that the chosen pattern names.

In the default build the whole path is combinational. The parameter `PIPE_STAGES` (0 to 3) adds registers at up to three cut points, one cycle of latency per register, while keeping a throughput of one word per clock.

Top module: `golay_decoder`

## Requirements
- R1: Rows 0 to 10 of B hold bit 11 set and bit j (j<11) set when (i+j) mod 11 lies in {0} ∪ {nonzero squares mod 11}. Row 11 holds bits 0 to 10 set and bit 11 clear. An error-free word, data in [23:12] and parity d·B in [11:0], returns its data half with both flags low.
- R2: Any error pattern of weight 1, 2 or 3, in any bit positions, yields the original 12 data bits on `data_o`.
- R3: `corrected_o` is 1 when an error pattern of weight 1 to 3 was removed, including one that lies only in the parity half. It is 0 for an error-free word.
- R4: Any error pattern of weight exactly 4 sets `uncorrectable_o` to 1 and `corrected_o` to 0.
- R5: When `uncorrectable_o` is 1, `data_o` equals bits [23:12] of the received word unchanged.
- R6: With `PIPE_STAGES` = 0 the block holds no state, and its outputs follow `rx_word_i` within the same cycle.
- R7: With `PIPE_STAGES` = N, the outputs for a word appear N clock edges after it is presented, and a new word is accepted on every clock.
- R8: `corrected_o` and `uncorrectable_o` are never both 1.
- R9: With `PIPE_STAGES` > 0, while `rst_ni` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the pipeline registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_word_i | input | 24 | Received word: data in [23:12], parity in [11:0] |
| data_o | output | 12 | Recovered data bits |
| corrected_o | output | 1 | A nonzero error pattern was removed |
| uncorrectable_o | output | 1 | The error pattern exceeds the correction limit |

## Verification
The sweep encodes every 12-bit data word and corrupts it with random patterns of each weight from 0 to 4. The bench checks every weight-1 to weight-3 pattern on one data word, and every weight-4 pattern on another. A search that covers only one half of the word, or that skips the s·B step, fails on errors that straddle both halves or sit mostly in the data half: it returns wrong data or raises the uncorrectable flag. A search whose weight threshold is one too loose miscorrects some weight-4 patterns, and the weight-4 sweep exposes this. A pipelined instance runs on the same stimulus to catch lost or extra register stages, and a reset check catches registers that leave reset nonzero.

// File: rtl/golay_pkg.sv
package golay_pkg;
  localparam int unsigned HALF_W = 12;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned CIRC_N = HALF_W - 1;
  localparam int unsigned T_MAX  = 3;
  // ones of the circulant core, index k = 0..10, stored MSB = k 0
  localparam logic [CIRC_N-1:0] CORE_SEED = 11'b11011100010;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic half_t b_row(input int unsigned i);
    half_t r;
    r = '0;
    if (i == CIRC_N) begin
      for (int unsigned j = 0; j < CIRC_N; j++) r[j] = 1'b1;
    end else begin
      for (int unsigned j = 0; j < CIRC_N; j++)
        r[j] = CORE_SEED[CIRC_N-1-((i + j) % CIRC_N)];
      r[CIRC_N] = 1'b1;
    end
    return r;
  endfunction

  function automatic half_t mul_b(input half_t v);
    half_t acc;
    acc = '0;
    for (int unsigned i = 0; i < HALF_W; i++)
      if (v[i]) acc = acc ^ b_row(i);
    return acc;
  endfunction

  function automatic int unsigned weight(input half_t v);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < HALF_W; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/golay_syndrome.sv
module golay_syndrome
  import golay_pkg::*;
(
  input  word_t word_i,
  output half_t syn_o
);
  half_t data_h, par_h;
  assign data_h = word_i[WORD_W-1:HALF_W];
  assign par_h  = word_i[HALF_W-1:0];
  assign syn_o  = par_h ^ mul_b(data_h);
endmodule

// File: rtl/golay_search.sv
module golay_search
  import golay_pkg::*;
(
  input  half_t syn_i,
  output word_t err_o,
  output logic  fail_o
);
  half_t syn2;
  half_t cand1 [HALF_W];
  half_t cand2 [HALF_W];
  logic [HALF_W-1:0] hit1, hit2;
  logic low1, low2;

  assign syn2 = mul_b(syn_i);
  assign low1 = weight(syn_i) <= T_MAX;
  assign low2 = weight(syn2) <= T_MAX;

  for (genvar i = 0; i < HALF_W; i++) begin : g_row
    assign cand1[i] = syn_i ^ b_row(i);
    assign cand2[i] = syn2 ^ b_row(i);
    assign hit1[i]  = weight(cand1[i]) <= T_MAX - 1;
    assign hit2[i]  = weight(cand2[i]) <= T_MAX - 1;
  end

  always_comb begin
    err_o  = '0;
    fail_o = 1'b0;
    if (low1) begin
      err_o = {{HALF_W{1'b0}}, syn_i};
    end else if (|hit1) begin
      for (int i = HALF_W - 1; i >= 0; i--)
        if (hit1[i]) begin
          err_o = {{HALF_W{1'b0}}, cand1[i]};
          err_o[HALF_W + i] = 1'b1;
        end
    end else if (low2) begin
      err_o = {syn2, {HALF_W{1'b0}}};
    end else if (|hit2) begin
      for (int i = HALF_W - 1; i >= 0; i--)
        if (hit2[i]) begin
          err_o = {cand2[i], {HALF_W{1'b0}}};
          err_o[i] = 1'b1;
        end
    end else begin
      fail_o = 1'b1;
    end
  end
endmodule

// File: rtl/golay_correct.sv
module golay_correct
  import golay_pkg::*;
(
  input  half_t rx_data_i,
  input  word_t err_i,
  input  logic  fail_i,
  output half_t data_o,
  output logic  cor_o,
  output logic  unc_o
);
  assign data_o = fail_i ? rx_data_i : (rx_data_i ^ err_i[WORD_W-1:HALF_W]);
  assign cor_o  = !fail_i && (err_i != '0);
  assign unc_o  = fail_i;
endmodule

// File: rtl/golay_stage.sv
module golay_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/golay_decoder.sv
module golay_decoder
  import golay_pkg::*;
#(
  parameter int unsigned PIPE_STAGES = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [23:0] rx_word_i,
  output logic [11:0] data_o,
  output logic        corrected_o,
  output logic        uncorrectable_o
);
  localparam int unsigned A_W = WORD_W + HALF_W;
  localparam int unsigned B_W = WORD_W + WORD_W + 1;
  localparam int unsigned C_W = HALF_W + 2;

  word_t word_a, word_b, err_s, err_b;
  half_t syn_s, syn_a, data_c;
  logic  fail_s, fail_b, cor_c, unc_c;
  logic [A_W-1:0] pa_d, pa_q;
  logic [B_W-1:0] pb_d, pb_q;
  logic [C_W-1:0] pc_d, pc_q;

  golay_syndrome u_syn (.word_i(rx_word_i), .syn_o(syn_s));

  assign pa_d = {rx_word_i, syn_s};
  if (PIPE_STAGES > 0) begin : g_cut_a
    golay_stage #(.W(A_W)) u_reg (.clk_i, .rst_ni, .d_i(pa_d), .q_o(pa_q));
  end else begin : g_pass_a
    assign pa_q = pa_d;
  end
  assign {word_a, syn_a} = pa_q;

  golay_search u_search (.syn_i(syn_a), .err_o(err_s), .fail_o(fail_s));

  assign pb_d = {word_a, err_s, fail_s};
  if (PIPE_STAGES > 1) begin : g_cut_b
    golay_stage #(.W(B_W)) u_reg (.clk_i, .rst_ni, .d_i(pb_d), .q_o(pb_q));
  end else begin : g_pass_b
    assign pb_q = pb_d;
  end
  assign {word_b, err_b, fail_b} = pb_q;

  golay_correct u_corr (
    .rx_data_i(word_b[WORD_W-1:HALF_W]),
    .err_i    (err_b),
    .fail_i   (fail_b),
    .data_o   (data_c),
    .cor_o    (cor_c),
    .unc_o    (unc_c)
  );

  assign pc_d = {data_c, cor_c, unc_c};
  if (PIPE_STAGES > 2) begin : g_cut_c
    golay_stage #(.W(C_W)) u_reg (.clk_i, .rst_ni, .d_i(pc_d), .q_o(pc_q));
  end else begin : g_pass_c
    assign pc_q = pc_d;
  end
  assign {data_o, corrected_o, uncorrectable_o} = pc_q;

  AST_CLEAN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_a == '0) |-> (err_s == '0 && !fail_s)); // R1
  AST_WEIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_s |-> ($countones(err_s) <= T_MAX)); // R2
  AST_RESIDUAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_b |-> ((word_b[HALF_W-1:0] ^ err_b[HALF_W-1:0]) == mul_b(data_c))); // R2
  AST_UNC_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_c |-> (data_c == word_b[WORD_W-1:HALF_W])); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corrected_o && uncorrectable_o)); // R8
endmodule

// File: tb/sim_golay_decoder.sv
module sim_golay_decoder;
  localparam int unsigned LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] rx = '0;
  logic [11:0] d0, d1;
  logic c0, c1, u0_unc, u1_unc;
  int checks = 0, fails = 0, nvec = 0;
  bit done = 0;
  logic [31:0] rs = 32'h1234_5678;
  logic [11:0] brow [12];
  logic [11:0] h_data [4];
  logic h_cor [4];
  logic h_unc [4];
  string h_tag [4];

  always #5 clk = ~clk;

  golay_decoder u0 (.clk_i(clk), .rst_ni(rst_n), .rx_word_i(rx),
    .data_o(d0), .corrected_o(c0), .uncorrectable_o(u0_unc));
  golay_decoder #(.PIPE_STAGES(LAT)) u1 (.clk_i(clk), .rst_ni(rst_n), .rx_word_i(rx),
    .data_o(d1), .corrected_o(c1), .uncorrectable_o(u1_unc));

  function automatic bit is_res(input int v);
    for (int k = 0; k < 11; k++) if ((k * k) % 11 == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [23:0] encode(input logic [11:0] d);
    logic [11:0] p;
    p = '0;
    for (int i = 0; i < 12; i++) if (d[i]) p ^= brow[i];
    return {d, p};
  endfunction

  function automatic logic [23:0] rand_err(input int k);
    logic [23:0] e;
    e = '0;
    while ($countones(e) < k) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      e[rs % 24] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [11:0] ad, input logic ac, input logic au,
                       input logic [11:0] ed, input logic ec, input logic eu);
    checks++;
    if (ad !== ed || ac !== ec || au !== eu) begin
      fails++;
      $display("FAIL %s: data=%h cor=%b unc=%b expected data=%h cor=%b unc=%b",
               tag, ad, ac, au, ed, ec, eu);
    end
  endtask

  task automatic apply(input logic [23:0] w, input logic [11:0] ed, input logic ec,
                       input logic eu, input string tag);
    @(negedge clk);
    if (nvec >= int'(LAT))
      check({"R7 pipe ", h_tag[(nvec - LAT) % 4]}, d1, c1, u1_unc,
            h_data[(nvec - LAT) % 4], h_cor[(nvec - LAT) % 4], h_unc[(nvec - LAT) % 4]);
    h_data[nvec % 4] = ed; h_cor[nvec % 4] = ec; h_unc[nvec % 4] = eu; h_tag[nvec % 4] = tag;
    rx = w;
    #1;
    check({"R6 comb ", tag}, d0, c0, u0_unc, ed, ec, eu);
    nvec++;
  endtask

  task automatic inject(input logic [11:0] d, input logic [23:0] e);
    logic [23:0] cw, w;
    int k;
    cw = encode(d);
    w = cw ^ e;
    k = $countones(e);
    if (k == 0)      apply(w, d, 1'b0, 1'b0, "R1 clean");
    else if (k <= 3) apply(w, d, 1'b1, 1'b0, "R2 R3 correctable");
    else             apply(w, w[23:12], 1'b0, 1'b1, "R4 R5 R8 four errors");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 11; i++) begin
      for (int j = 0; j < 11; j++) brow[i][j] = is_res((i + j) % 11);
      brow[i][11] = 1'b1;
    end
    brow[11] = 12'h7FF;
    rx = encode(12'h9C3) ^ 24'h000401;
    #23;
    check("R9 reset", d1, c1, u1_unc, 12'h000, 1'b0, 1'b0);
    check("R6 comb during reset", d0, c0, u0_unc, 12'h9C3, 1'b1, 1'b0);
    rst_n = 1'b1;
    for (int d = 0; d < 4096; d++)
      for (int k = 0; k <= 4; k++) inject(12'(d), rand_err(k));
    inject(12'hA5C, 24'h0);
    for (int a = 0; a < 24; a++) begin
      inject(12'hA5C, 24'h1 << a);
      for (int b = a + 1; b < 24; b++) begin
        inject(12'hA5C, (24'h1 << a) | (24'h1 << b));
        for (int c = b + 1; c < 24; c++)
          inject(12'hA5C, (24'h1 << a) | (24'h1 << b) | (24'h1 << c));
      end
    end
    for (int a = 0; a < 24; a++)
      for (int b = a + 1; b < 24; b++)
        for (int c = b + 1; c < 24; c++)
          for (int e = c + 1; e < 24; e++)
            inject(12'h3F1, (24'h1 << a) | (24'h1 << b) | (24'h1 << c) | (24'h1 << e));
    for (int f = 0; f < int'(LAT); f++) inject(12'h000, 24'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule